// File: doc/BRIEF.md
# Two-Class Probability Normalizer

This block turns a pair of signed class scores, one for the keyword class and one for the non-keyword class, into a pair of fixed-point probabilities that add up to exactly one. Each score first passes through a rectifier that looks only at the sign bit: a negative score becomes zero and any other score passes through unchanged. The keyword probability is then the rectified keyword score divided by the sum of both rectified scores. The non-keyword probability is what remains after subtracting that value from one.

The division is not done by a hardware divider. It uses a linear-mode, shift-and-add iteration that produces one quotient bit per clock cycle. A single adder-subtractor is reused in every iteration, and the sign of the running residual selects whether it adds or subtracts. Subtraction is done by adding the two's complement, and doubling is done by shifting. Only one division is needed per frame because there are only two classes.

A caller pulses `start_i` while the block is idle, keeps the scores valid in that cycle, and waits for the one-cycle `done_o` strobe. The probabilities stay on the outputs until the next strobe.

Top module: `two_class_norm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `busy_o` and `done_o` go to 0 and both probability outputs go to 0.
- R2: A score whose sign bit (bit SCORE_W-1, two's complement) is set counts as zero. A zero or positive score counts at its own value.
- R3: The probabilities are unsigned PROB_W-bit values in which 2^(PROB_W-1) stands for 1.0 (128 by default). When the rectified scores are a (keyword) and b (non-keyword) and a+b > 0, `prob_kw_o` equals floor(a·2^(PROB_W-1)/(a+b)).
- R4: `prob_nk_o` equals 2^(PROB_W-1) minus `prob_kw_o`, so at every done strobe the two outputs add up to exactly 2^(PROB_W-1).
- R5: When both rectified scores are zero, the block does no iterations. `busy_o` stays low, and in the cycle after the start edge `done_o` is high and both outputs equal 2^(PROB_W-2) (one half).
- R6: When at least one rectified score is nonzero, `busy_o` is high for exactly PROB_W cycles after the start edge. `done_o` is high in the cycle right after `busy_o` falls.
- R7: A `start_i` pulse that arrives while `busy_o` is high is ignored. The run in progress keeps its result and its timing.
- R8: Between done strobes the probability outputs keep their values, whatever the score and start inputs do.
- R9: `done_o` is high for one cycle for each accepted start. A start accepted during the done cycle begins a new operation at once.
- R10: `busy_o` and `done_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| kw_score_i | input | SCORE_W | Signed keyword class score |
| nk_score_i | input | SCORE_W | Signed non-keyword class score |
| busy_o | output | 1 | Division iterations in progress |
| done_o | output | 1 | One-cycle result strobe |
| prob_kw_o | output | PROB_W | Keyword probability, 2^(PROB_W-1) = 1.0 |
| prob_nk_o | output | PROB_W | Non-keyword probability, 2^(PROB_W-1) = 1.0 |

## Verification
The bench targets the edges of the quotient range.

- **Zero non-keyword score.** A zero non-keyword score must give exactly 1.0. A design that drops the integer quotient bit would wrap this to 0.
- **Tiny keyword against a huge non-keyword.** A design with a short residual register would return a wrong nonzero fraction here.
- **Both scores at full scale.** This pushes the denominator past the score width. A design that does not carry the extra sum bit would give a wrong half.
- **Negative scores.** These catch a rectifier that tests the wrong bit or lets a negative magnitude through.
- **Both scores negative or zero.** This must take the one-cycle tie path. A design that iterates on a zero divisor would hang at all-ones or stretch the latency.
- **Start handling.** Start is held high through a whole run and also re-issued in the done cycle. A design that restarts while busy, or refuses a start in the done cycle, shifts the strobe away from the cycle the reference model predicts.

// File: rtl/norm_pkg.sv
// Package: shared constants helpers for the two-class normalizer.
// Assumes PROB_W >= 2 so that both 1.0 and 0.5 are representable.
package norm_pkg;
    // Fixed-point 1.0 for a PROB_W-bit probability with PROB_W-1 fraction bits
    function automatic int unsigned prob_one(input int unsigned pw);
        return 32'd1 << (pw - 1);
    endfunction

    // Fixed-point 0.5 in the same format
    function automatic int unsigned prob_half(input int unsigned pw);
        return 32'd1 << (pw - 2);
    endfunction
endpackage

// File: rtl/relu_clamp.sv
// Module: relu_clamp
// Rectifies one signed score by testing its sign bit and muxing in zero.
// Output is the unsigned magnitude (sign bit dropped). Purely combinational.
module relu_clamp #(
    parameter int W = 16
) (
    input  logic [W-1:0] score_i,
    output logic [W-2:0] mag_o
);
    // Sign bit selects zero for negative inputs, passthrough otherwise
    always_comb begin
        mag_o = score_i[W-1] ? '0 : score_i[W-2:0];
    end
endmodule

// File: rtl/addsub_unit.sv
// Module: addsub_unit
// One shared adder; subtraction adds the bitwise inverse plus a carry-in
// of one (two's complement). Wraps modulo 2^W.
module addsub_unit #(
    parameter int W = 18
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o
);
    logic [W-1:0] b_sel;

    // Operand conditioning and single addition with carry-in
    always_comb begin
        b_sel = sub_i ? ~b_i : b_i;
        res_o = a_i + b_sel + {{(W-1){1'b0}}, sub_i};
    end
endmodule

// File: rtl/cordic_div_core.sv
// Module: cordic_div_core
// Linear-mode non-restoring divider producing QW quotient bits, one per
// cycle, MSB weight 2^0. Assumes num_i <= den_i and den_i != 0 on load,
// so the quotient fits in QW bits with QW-1 fraction bits.
// last_o/quot_nxt_o expose the final iteration combinationally so the
// caller can register the result at the same edge.
module cordic_div_core #(
    parameter int NUM_W = 15,
    parameter int QW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [NUM_W:0]   den_i,
    output logic             busy_o,
    output logic             last_o,
    output logic [QW-1:0]    quot_nxt_o
);
    localparam int DEN_W = NUM_W + 1;
    localparam int REM_W = DEN_W + 2;
    localparam int CNT_W = $clog2(QW + 1);

    logic [REM_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [QW-1:0]    quot_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             dir_sub;
    logic [REM_W-1:0] step_res;

    // Direction control: non-negative residual subtracts, negative adds
    always_comb begin
        dir_sub = ~rem_q[REM_W-1];
    end

    addsub_unit #(.W(REM_W)) u_addsub (
        .a_i   (rem_q),
        .b_i   ({2'b00, den_q}),
        .sub_i (dir_sub),
        .res_o (step_res)
    );

    // New quotient bit from the sign after the step; final-iteration flag
    always_comb begin
        quot_nxt_o = {quot_q[QW-2:0], ~step_res[REM_W-1]};
        last_o     = busy_q && (cnt_q == CNT_W'(QW - 1));
        busy_o     = busy_q;
    end

    // Iteration state: load operands, then shift-double residual each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= '0;
            quot_q <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (load_i) begin
            rem_q  <= {{(REM_W-NUM_W){1'b0}}, num_i};
            den_q  <= den_i;
            quot_q <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            rem_q  <= {step_res[REM_W-2:0], 1'b0};
            quot_q <= quot_nxt_o;
            cnt_q  <= cnt_q + 1'b1;
            if (last_o) begin
                busy_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/two_class_norm.sv
// Module: two_class_norm (top)
// Rectifies two signed class scores and normalizes them into probabilities
// that sum to exactly 1.0 (2^(PROB_W-1)). Starts are taken only while idle.
// An all-zero pair bypasses the divider and returns one half each.
module two_class_norm
    import norm_pkg::*;
#(
    parameter int SCORE_W = 16,
    parameter int PROB_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic signed [SCORE_W-1:0] kw_score_i,
    input  logic signed [SCORE_W-1:0] nk_score_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [PROB_W-1:0]         prob_kw_o,
    output logic [PROB_W-1:0]         prob_nk_o
);
    localparam int MAG_W = SCORE_W - 1;
    localparam logic [PROB_W-1:0] P_ONE  = PROB_W'(prob_one(PROB_W));
    localparam logic [PROB_W-1:0] P_HALF = PROB_W'(prob_half(PROB_W));

    logic [SCORE_W-1:0] score_a [2];
    logic [MAG_W-1:0]   mag_a   [2];
    logic [MAG_W:0]     den_sum;
    logic               accept, load, tie;
    logic               core_busy, core_last;
    logic [PROB_W-1:0]  quot_nxt;
    logic [PROB_W-1:0]  kw_q, nk_q;
    logic               done_q;

    // Gather both scores for the rectifier array
    always_comb begin
        score_a[0] = kw_score_i;
        score_a[1] = nk_score_i;
    end

    for (genvar g = 0; g < 2; g++) begin : g_relu
        relu_clamp #(.W(SCORE_W)) u_relu (
            .score_i (score_a[g]),
            .mag_o   (mag_a[g])
        );
    end

    // Divisor and start qualification
    always_comb begin
        den_sum = {1'b0, mag_a[0]} + {1'b0, mag_a[1]};
        accept  = start_i && !core_busy;
        load    = accept && (den_sum != '0);
        tie     = accept && (den_sum == '0);
    end

    cordic_div_core #(.NUM_W(MAG_W), .QW(PROB_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .num_i      (mag_a[0]),
        .den_i      (den_sum),
        .busy_o     (core_busy),
        .last_o     (core_last),
        .quot_nxt_o (quot_nxt)
    );

    // Result registers and done strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kw_q   <= '0;
            nk_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tie) begin
                kw_q   <= P_HALF;
                nk_q   <= P_HALF;
                done_q <= 1'b1;
            end else if (core_last) begin
                kw_q   <= quot_nxt;
                nk_q   <= P_ONE - quot_nxt;
                done_q <= 1'b1;
            end
        end
    end

    // Output mapping
    always_comb begin
        busy_o    = core_busy;
        done_o    = done_q;
        prob_kw_o = kw_q;
        prob_nk_o = nk_q;
    end
endmodule

// File: rtl/two_class_norm_chk.sv
// Module: two_class_norm_chk
// Port-level properties of the normalizer; attached by bind below.
// Counts busy cycles to check the iteration window without deep $past.
module two_class_norm_chk
    import norm_pkg::*;
#(
    parameter int SCORE_W = 16,
    parameter int PROB_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_i,
    input logic signed [SCORE_W-1:0] kw_score_i,
    input logic signed [SCORE_W-1:0] nk_score_i,
    input logic                      busy_o,
    input logic                      done_o,
    input logic [PROB_W-1:0]         prob_kw_o,
    input logic [PROB_W-1:0]         prob_nk_o
);
    localparam int RUN_W = $clog2(PROB_W + 2);
    localparam logic [PROB_W:0] C_ONE  = (PROB_W+1)'(prob_one(PROB_W));
    localparam logic [PROB_W-1:0] C_HALF = PROB_W'(prob_half(PROB_W));

    logic [RUN_W-1:0] busy_run;

    // Length of the current busy stretch
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= '0;
        else if (busy_o) busy_run <= busy_run + 1'b1;
        else busy_run <= '0;
    end

    p_sum_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ({1'b0, prob_kw_o} + {1'b0, prob_nk_o}) == C_ONE);

    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> {1'b0, prob_kw_o} <= C_ONE);

    p_tie_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && kw_score_i <= 0 && nk_score_i <= 0)
        |=> (done_o && !busy_o && prob_kw_o == C_HALF && prob_nk_o == C_HALF));

    p_enter_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (kw_score_i > 0 || nk_score_i > 0))
        |=> (busy_o && !done_o));

    p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o && busy_run == RUN_W'(PROB_W)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(prob_kw_o) || !$stable(prob_nk_o)) |-> done_o);

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
endmodule

bind two_class_norm two_class_norm_chk #(.SCORE_W(SCORE_W), .PROB_W(PROB_W)) chk_i (.*);

// File: tb/two_class_norm_tb_top.sv
// Bench: behavioural cycle model (integers only) compared every cycle.
module two_class_norm_tb_top;
    localparam int SW  = 16;
    localparam int PW  = 8;
    localparam int ONE = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic signed [SW-1:0] kw_score_i = '0;
    logic signed [SW-1:0] nk_score_i = '0;
    logic busy_o, done_o;
    logic [PW-1:0] prob_kw_o, prob_nk_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_tag = "R3";

    int m_busy = 0, m_cnt = 0, m_done = 0, m_kw = 0, m_nk = 0, m_pend = 0;

    always #4 clk = ~clk;

    two_class_norm #(.SCORE_W(SW), .PROB_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .kw_score_i(kw_score_i), .nk_score_i(nk_score_i),
        .busy_o(busy_o), .done_o(done_o),
        .prob_kw_o(prob_kw_o), .prob_nk_o(prob_nk_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference model, updated at each rising edge
    always @(posedge clk) begin
        int a, b;
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_done = 0; m_kw = 0; m_nk = 0;
        end else begin
            m_done = 0;
            if (m_busy != 0) begin
                m_cnt++;
                if (m_cnt == PW) begin
                    m_busy = 0; m_done = 1; m_kw = m_pend; m_nk = ONE - m_pend;
                end
            end else if (start_i) begin
                a = (int'(kw_score_i) < 0) ? 0 : int'(kw_score_i);
                b = (int'(nk_score_i) < 0) ? 0 : int'(nk_score_i);
                if (a + b == 0) begin
                    m_done = 1; m_kw = ONE / 2; m_nk = ONE / 2;
                end else begin
                    m_busy = 1; m_cnt = 0; m_pend = (a * ONE) / (a + b);
                end
            end
        end
        if (cyc == 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Compare on every falling edge once out of reset
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 busy", int'(busy_o), m_busy);
            chk("R9 done", int'(done_o), m_done);
            chk({cur_tag, " kw"}, int'(prob_kw_o), m_kw);
            chk({cur_tag, " nk / R8"}, int'(prob_nk_o), m_nk);
            chk("R10 busy&done", int'(busy_o && done_o), 0);
            if (done_o) chk("R4 sum", int'(prob_kw_o) + int'(prob_nk_o), ONE);
        end
    end

    task automatic run(input int kw, input int nk, input string tag);
        @(negedge clk);
        cur_tag = tag;
        kw_score_i = SW'(kw);
        nk_score_i = SW'(nk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        kw_score_i = SW'(-kw);
        nk_score_i = SW'(nk + 7);
        repeat (11) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 kw", int'(prob_kw_o), 0);
        chk("R1 nk", int'(prob_nk_o), 0);
        rst_n = 1'b1;

        run(300, 100, "R3");
        run(7, 3, "R3");
        run(100, 0, "R3");
        run(0, 5, "R4");
        run(1, 32767, "R3");
        run(32767, 32767, "R3");
        run(-50, 20, "R2");
        run(40, -1, "R2");
        run(-3, -9, "R5");
        run(0, 0, "R5");

        // R7: start held high through runs with changing scores
        @(negedge clk);
        cur_tag = "R7";
        start_i = 1'b1;
        for (int i = 0; i < 25; i++) begin
            kw_score_i = SW'(i * 37 + 1);
            nk_score_i = SW'(500 - i * 11);
            @(negedge clk);
        end
        start_i = 1'b0;
        repeat (10) @(negedge clk);

        // R8: idle with changing scores, outputs must hold
        cur_tag = "R8";
        for (int i = 0; i < 12; i++) begin
            kw_score_i = SW'(i * 1000);
            nk_score_i = SW'(-i);
            @(negedge clk);
        end

        // R9: tie then a fresh start accepted in the done cycle
        cur_tag = "R9";
        kw_score_i = '0; nk_score_i = '0; start_i = 1'b1;
        @(negedge clk);
        kw_score_i = SW'(90); nk_score_i = SW'(10);
        @(negedge clk);
        start_i = 1'b0;
        repeat (12) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule